// File: doc/BRIEF.md
# Accumulator-Based Test Pattern Generator with Target Embedding Tracker

This block is an additive pattern source for built-in self-test. A start pulse presets a W-bit accumulator to a seed and captures an increment and a small set of target vectors. After that, the accumulator adds the captured increment on every clock and wraps modulo 2^W. The pattern at step i is therefore seed + i·increment.

While the sequence runs, the block watches for each target vector. It records the step at which each target first appears. It also reports the number of steps needed to reach every target, which is the largest of those step indices.

The run ends in one of two ways. Either every target has been seen, or the whole 2^W-step cycle has been covered. In the second case the block flags that at least one target can never be produced with this seed and increment. This happens, for example, with an even increment. Choosing a good increment is left to the user of the block.

Top module: `accum_tpg`

## Requirements
- R1: On a clock edge with `start` high, the block captures `seedIn`, `incIn` and all of `tgtIn`, loads the pattern with the seed, and clears the step count, the hit flags, the indices, `seqLen`, `done` and `unreachable`. Changes on these inputs after that edge have no effect until the next start.
- R2: On each clock edge after the start edge until `done`, the pattern adds the captured increment modulo 2^W. The pattern present during step i is (seed + i·inc) mod 2^W, and step 0 is the cycle right after the start edge.
- R3: Target k occupies bits [k·W +: W] of `tgtIn` and of `hitIdx`. At the end of the first step i whose pattern equals target k, `hitFlags[k]` is set and `hitIdx[k]` holds i.
- R4: A hit flag and its index are sticky. A later appearance of the same value changes neither of them before the next start.
- R5: `seqLen` equals the largest index among the targets that were hit, and is 0 if none was hit.
- R6: `done` rises at the end of the step in which the last outstanding target is hit. That is S+1 edges after the start edge, where S is that step. From then on the pattern, the flags, the indices and `seqLen` hold, and the pattern stays at seed + (S+1)·inc.
- R7: If step 2^W−1 ends with any target still unhit, `done` and `unreachable` both rise (S = 2^W−1). `unreachable` is never high while every target is hit.
- R8: A target equal to the seed is hit at index 0. Identical targets are hit at the same step with the same index.
- R9: While `rst_n` is low, the pattern, the flags, the indices, `seqLen`, `done` and `unreachable` are all 0.
- R10: A start pulse during an unfinished run abandons that run and begins a new one from the newly presented inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Preset: capture inputs and begin a run |
| seedIn | input | W | Initial pattern value |
| incIn | input | W | Per-step increment |
| tgtIn | input | M·W | Target vectors, target k in bits [k·W +: W] |
| patOut | output | W | Current generated pattern |
| hitFlags | output | M | Sticky per-target hit flags |
| hitIdx | output | M·W | Step at which each target was first produced |
| seqLen | output | W | Worst-case step index over hit targets |
| done | output | 1 | Run finished |
| unreachable | output | 1 | Run ended with at least one target never produced |

## Verification
The first pattern is a negative increment, the all-ones value, with four targets just below 2^W. It checks that the wrap-around arithmetic places the targets in reverse order and that the sequence length is the worst case and not the last-listed target. An increment of one with a target one step behind the seed drives the length to its 2^W−1 ceiling. Even and zero increments separate a clean finish from the unreachable finish, and with a step of half the range the same value comes back, which tests stickiness. A mid-run change of inputs, followed by a mid-run restart, tells the captured copies apart from the live ports.

// File: rtl/atpg_pkg.sv
package atpg_pkg;

  // Strobes issued by the sequencer to the datapath each cycle.
  typedef struct packed {
    logic load;     // capture inputs and preset the accumulator
    logic advance;  // examine the current step and move to the next
  } atpgStrobe_t;

endpackage

// File: rtl/atpg_slot.sv
// One target tracker: holds a captured target, a sticky hit flag and
// the step index of the first match.
module atpg_slot #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         advance,
  input  logic [W-1:0] tgtIn,
  input  logic [W-1:0] patIn,
  input  logic [W-1:0] stepIn,
  output logic         hitQ,
  output logic [W-1:0] idxQ,
  output logic         hitNext
);

  logic [W-1:0] tgtQ;
  logic         matchNow;

  assign matchNow = advance && !hitQ && (patIn == tgtQ);
  assign hitNext  = hitQ | matchNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgtQ <= '0;
      hitQ <= 1'b0;
      idxQ <= '0;
    end else if (load) begin
      tgtQ <= tgtIn;
      hitQ <= 1'b0;
      idxQ <= '0;
    end else if (matchNow) begin
      hitQ <= 1'b1;
      idxQ <= stepIn;
    end
  end

  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hitQ && !load |=> hitQ);  // R4
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hitQ && !load |=> $stable(idxQ));  // R4
  AST_HIT_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !hitQ ##1 hitQ |-> $past(patIn) == $past(tgtQ));  // R3

endmodule

// File: rtl/atpg_datapath.sv
// Accumulator, captured operands, target trackers and the length register.
module atpg_datapath
  import atpg_pkg::*;
#(
  parameter int W = 6,
  parameter int M = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  atpgStrobe_t    strobe,
  input  logic [W-1:0]   seedIn,
  input  logic [W-1:0]   incIn,
  input  logic [M*W-1:0] tgtIn,
  input  logic [W-1:0]   stepIn,
  output logic [W-1:0]   patQ,
  output logic [M-1:0]   hitVec,
  output logic [M*W-1:0] idxFlat,
  output logic [W-1:0]   lenQ,
  output logic           allHitNext
);

  logic [W-1:0] seedQ;
  logic [W-1:0] incQ;
  logic [M-1:0] hitNextVec;
  logic [M-1:0] newHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seedQ <= '0;
      incQ  <= '0;
      patQ  <= '0;
    end else if (strobe.load) begin
      seedQ <= seedIn;
      incQ  <= incIn;
      patQ  <= seedIn;
    end else if (strobe.advance) begin
      patQ <= patQ + incQ;
    end
  end

  for (genvar k = 0; k < M; k++) begin : gSlot
    atpg_slot #(.W(W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (strobe.load),
      .advance (strobe.advance),
      .tgtIn   (tgtIn[k*W +: W]),
      .patIn   (patQ),
      .stepIn  (stepIn),
      .hitQ    (hitVec[k]),
      .idxQ    (idxFlat[k*W +: W]),
      .hitNext (hitNextVec[k])
    );

    AST_LEN_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      hitVec[k] |-> idxFlat[k*W +: W] <= lenQ);  // R5
  end

  assign newHit     = hitNextVec & ~hitVec;
  assign allHitNext = &hitNextVec;

  // Steps are visited in increasing order, so the latest new hit is the max.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenQ <= '0;
    end else if (strobe.load) begin
      lenQ <= '0;
    end else if (strobe.advance && (|newHit)) begin
      lenQ <= stepIn;
    end
  end

  AST_PATTERN_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |-> patQ == W'(seedQ + stepIn * incQ));  // R2

endmodule

// File: rtl/atpg_ctrl.sv
// Sequencer: step counter, run/finish state and strobe generation.
module atpg_ctrl
  import atpg_pkg::*;
#(
  parameter int W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        allHitNext,
  input  logic        allHit,
  output atpgStrobe_t strobe,
  output logic [W-1:0] stepQ,
  output logic        doneQ,
  output logic        unreachQ
);

  localparam logic [W-1:0] STEP_LAST = {W{1'b1}};

  logic activeQ;

  always_comb begin
    strobe.load    = start;
    strobe.advance = activeQ && !start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeQ  <= 1'b0;
      stepQ    <= '0;
      doneQ    <= 1'b0;
      unreachQ <= 1'b0;
    end else if (strobe.load) begin
      activeQ  <= 1'b1;
      stepQ    <= '0;
      doneQ    <= 1'b0;
      unreachQ <= 1'b0;
    end else if (strobe.advance) begin
      stepQ <= stepQ + W'(1);
      if (allHitNext) begin
        activeQ <= 1'b0;
        doneQ   <= 1'b1;
      end else if (stepQ == STEP_LAST) begin
        activeQ  <= 1'b0;
        doneQ    <= 1'b1;
        unreachQ <= 1'b1;
      end
    end
  end

  AST_DONE_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ && !unreachQ |-> allHit);  // R6
  AST_UNREACH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    unreachQ |-> doneQ && !allHit);  // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ && !start |=> $stable(stepQ) && doneQ);  // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !doneQ && !unreachQ && stepQ == '0);  // R1

endmodule

// File: rtl/accum_tpg.sv
module accum_tpg
  import atpg_pkg::*;
#(
  parameter int W = 6,
  parameter int M = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   seedIn,
  input  logic [W-1:0]   incIn,
  input  logic [M*W-1:0] tgtIn,
  output logic [W-1:0]   patOut,
  output logic [M-1:0]   hitFlags,
  output logic [M*W-1:0] hitIdx,
  output logic [W-1:0]   seqLen,
  output logic           done,
  output logic           unreachable
);

  atpgStrobe_t strobe;
  logic [W-1:0] stepQ;
  logic         allHitNext;

  atpg_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .allHitNext (allHitNext),
    .allHit     (&hitFlags),
    .strobe     (strobe),
    .stepQ      (stepQ),
    .doneQ      (done),
    .unreachQ   (unreachable)
  );

  atpg_datapath #(.W(W), .M(M)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .seedIn     (seedIn),
    .incIn      (incIn),
    .tgtIn      (tgtIn),
    .stepIn     (stepQ),
    .patQ       (patOut),
    .hitVec     (hitFlags),
    .idxFlat    (hitIdx),
    .lenQ       (seqLen),
    .allHitNext (allHitNext)
  );

endmodule

// File: tb/accum_tpg_tb.sv
module accum_tpg_tb;

  localparam int W = 6;
  localparam int M = 4;
  localparam int NV = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   seedIn = '0;
  logic [W-1:0]   incIn = '0;
  logic [M*W-1:0] tgtIn = '0;
  logic [W-1:0]   patOut;
  logic [M-1:0]   hitFlags;
  logic [M*W-1:0] hitIdx;
  logic [W-1:0]   seqLen;
  logic           done;
  logic           unreachable;

  int passCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  accum_tpg #(.W(W), .M(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seedIn(seedIn), .incIn(incIn),
    .tgtIn(tgtIn), .patOut(patOut), .hitFlags(hitFlags), .hitIdx(hitIdx),
    .seqLen(seqLen), .done(done), .unreachable(unreachable)
  );

  // seed, inc, t0, t1, t2, t3, expected length, expected unreachable
  localparam logic [42:0] VEC [NV] = '{
    {6'd0,  6'd63, 6'd59, 6'd60, 6'd61, 6'd62, 6'd5,  1'b0},
    {6'd10, 6'd1,  6'd10, 6'd11, 6'd20, 6'd9,  6'd63, 1'b0},
    {6'd0,  6'd2,  6'd4,  6'd8,  6'd3,  6'd6,  6'd4,  1'b1},
    {6'd5,  6'd37, 6'd5,  6'd5,  6'd42, 6'd15, 6'd2,  1'b0},
    {6'd7,  6'd0,  6'd7,  6'd8,  6'd7,  6'd7,  6'd0,  1'b1},
    {6'd0,  6'd32, 6'd32, 6'd0,  6'd1,  6'd1,  6'd1,  1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int firstStep(input int s, input int inc, input int t);
    for (int k = 0; k < 64; k++)
      if (((s + k * inc) & 63) == t) return k;
    return 64;
  endfunction

  task automatic startRun(input int s, input int inc, input int t0, input int t1,
                          input int t2, input int t3);
    @(negedge clk);
    seedIn = W'(s);
    incIn  = W'(inc);
    tgtIn  = {W'(t3), W'(t2), W'(t1), W'(t0)};
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic finishRun(input int s, input int inc, input int t0, input int t1,
                           input int t2, input int t3, input int tLen, input bit tUnr);
    int tg[M];
    int fs;
    int mLen;
    bit miss;
    int cyc;
    int lastStep;
    logic [W-1:0] patHold;
    logic [M-1:0] hitHold;
    tg[0] = t0; tg[1] = t1; tg[2] = t2; tg[3] = t3;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    mLen = 0;
    miss = 1'b0;
    for (int k = 0; k < M; k++) begin
      fs = firstStep(s, inc, tg[k]);
      check(hitFlags[k] == (fs < 64), "R3 hit flag", hitFlags[k], fs < 64);
      if (fs < 64) begin
        check(hitIdx[k*W +: W] == W'(fs), "R3 hit index", hitIdx[k*W +: W], fs);
        if (fs > mLen) mLen = fs;
      end else miss = 1'b1;
    end
    check(mLen == tLen && seqLen == W'(mLen), "R5 sequence length", seqLen, mLen);
    check(unreachable == miss && miss == tUnr, "R7 unreachable flag", unreachable, miss);
    lastStep = miss ? 63 : mLen;
    check(cyc == lastStep + 1, "R6 done timing", cyc, lastStep + 1);
    check(patOut == W'((s + (lastStep + 1) * inc) & 63), "R6 final pattern",
          patOut, (s + (lastStep + 1) * inc) & 63);
    patHold = patOut;
    hitHold = hitFlags;
    repeat (4) @(negedge clk);
    check(done && patOut == patHold && hitFlags == hitHold, "R6 hold after done",
          patOut, patHold);
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check(patOut == '0 && hitFlags == '0 && hitIdx == '0, "R9 reset outputs",
          patOut, 0);
    check(!done && !unreachable && seqLen == '0, "R9 reset flags", done, 0);
    rst_n = 1'b1;

    // Table walk: R3 R5 R6 R7 R8 (entries 4,5 cover seed match and duplicates; 6 R4)
    for (int v = 0; v < NV; v++) begin
      startRun(VEC[v][42:37], VEC[v][36:31], VEC[v][30:25], VEC[v][24:19],
               VEC[v][18:13], VEC[v][12:7]);
      finishRun(VEC[v][42:37], VEC[v][36:31], VEC[v][30:25], VEC[v][24:19],
                VEC[v][18:13], VEC[v][12:7], VEC[v][6:1], VEC[v][0]);
    end

    // R8: seed-equal and duplicate targets share index 0
    startRun(9, 3, 9, 12, 9, 12);
    finishRun(9, 3, 9, 12, 9, 12, 1, 1'b0);
    check(hitIdx[0 +: W] == '0 && hitIdx[2*W +: W] == '0 &&
          hitIdx[W +: W] == hitIdx[3*W +: W], "R8 seed and duplicate index",
          hitIdx[W +: W], 1);

    // R4: value reappears after hit; index must stay at first step
    startRun(0, 32, 32, 0, 1, 1);
    repeat (10) @(negedge clk);
    check(hitFlags[0] && hitIdx[0 +: W] == W'(1), "R4 sticky index",
          hitIdx[0 +: W], 1);

    // R1 R2: linear sequence, then live inputs changed mid-run
    startRun(3, 5, 2, 1, 0, 63);
    for (int st = 0; st < 6; st++) begin
      check(patOut == W'((3 + st * 5) & 63), "R2 pattern step", patOut,
            (3 + st * 5) & 63);
      if (st == 1) begin
        seedIn = 6'd40;
        incIn  = 6'd1;
        tgtIn  = {6'd20, 6'd20, 6'd20, 6'd20};
      end
      @(negedge clk);
    end
    check(patOut == W'(33) && !done && hitFlags == '0, "R1 inputs ignored mid-run",
          patOut, 33);

    // R10: restart before the run finishes
    startRun(0, 63, 59, 60, 61, 62);
    finishRun(0, 63, 59, 60, 61, 62, 5, 1'b0);
    check(hitFlags == 4'b1111, "R10 restart result", hitFlags, 15);

    // R1: start clears a finished run
    @(negedge clk);
    seedIn = 6'd17;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    check(patOut == W'(17) && hitFlags == '0 && !done && seqLen == '0,
          "R1 preset clears", patOut, 17);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule